// File: doc/BRIEF.md
# Wait-State Register Completer for APB

This block is an APB completer that holds a small bank of 32-bit word registers. An upstream bridge decodes the upper address space and drives the select line. Inside the block, only the word-index bits of the address are decoded. The two byte-offset bits are ignored, because every access is word-aligned.

Each transfer is stretched by a configurable number of wait states. The block loads a down-counter during the setup phase. It raises the ready signal only when that counter has reached zero in the access phase. The wait count comes from a static input, so one build can serve fast and slow configurations.

An access whose address has any bit set above the word-index field lies outside the window. Such an access still completes after the same wait states, but it raises the slave-error flag on the completing cycle. A write to such an address is dropped, and a read returns zero.

Top module: `apb_wait_regs`

## Requirements
- R1: While presetn is low, pready and pslverr stay low even if psel and penable are high. After reset, every register reads back as zero.
- R2: With waitCycles equal to W, pready stays low for the first W access-phase cycles. It rises on access cycle W+1, so a transfer lasts W+2 cycles including the setup cycle. W equal to zero gives a two-cycle transfer.
- R3: pready is high only when psel and penable are both high. It is always low during the setup cycle and while the bus is idle.
- R4: A write to a valid address stores pwdata into register paddr[3:2] on the completing cycle. paddr[1:0] has no effect on which register is written.
- R5: A read from a valid address presents the register selected by paddr[3:2] on prdata in the completing cycle. paddr[1:0] has no effect on the data returned.
- R6: An address with any bit above bit 3 set completes with pslverr high. A write to it leaves every register unchanged, and a read from it returns zero on prdata.
- R7: pslverr is low in every cycle other than a completing cycle, including the wait cycles of a transfer to an invalid address.
- R8: The wait counter reloads on every setup phase. Back-to-back transfers, with no idle cycle between them, each receive the full W wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| waitCycles | input | WAIT_W (4) | Static count of wait states per transfer |
| paddr | input | ADDR_W (32) | Byte address; bits 3:2 pick the register, bits above 3 must be zero |
| psel | input | 1 | Select from the upstream decoder |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid on the completing cycle |
| pready | output | 1 | Transfer completes when high in the access phase |
| pslverr | output | 1 | Error flag for an access outside the window |

## Verification
The bench builds the block with its default parameters: a 32-bit address, four word registers and a 4-bit wait count. With only four registers and four byte offsets, every register and offset combination can be written and read back for each wait count from 0 to 3, and again at the maximum of 15. Sweeping the wait counts measures the transfer length directly at both ends of the counter's range. Invalid addresses are probed with a single stray bit at several positions from bit 4 up to bit 31. The register contents are then read back to show that nothing was overwritten. Back-to-back transfers fall out of the sweep, because the bench starts each new setup phase directly after a completion.

// File: rtl/apb_wait_regs_pkg.sv
package apb_wait_regs_pkg;

  // Strobes passed from the control path to the datapath
  typedef struct packed {
    logic done;   // completing cycle of a transfer
    logic wrEn;   // commit write data into the selected register
    logic rdEn;   // drive read data during a read access phase
    logic err;    // completing cycle of an out-of-window access
  } ctrlStrb_t;

endpackage

// File: rtl/apb_wait_regs_ctrl.sv
module apb_wait_regs_ctrl
  import apb_wait_regs_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [WAIT_W-1:0] waitCycles,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              addrBad,
  output ctrlStrb_t         strb,
  output logic              pready,
  output logic              pslverr
);

  logic              setupPh;
  logic              accessPh;
  logic [WAIT_W-1:0] waitCnt;
  logic              armed;
  logic              cntZero;
  logic              readyInt;

  assign setupPh  = psel & ~penable;
  assign accessPh = psel & penable;
  assign cntZero  = (waitCnt == '0);

  // Down-counter: loaded in setup, decremented through the access phase.
  // The armed flag marks a transfer that has seen its setup cycle.
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      waitCnt <= '0;
      armed   <= 1'b0;
    end else if (setupPh) begin
      waitCnt <= waitCycles;
      armed   <= 1'b1;
    end else if (accessPh) begin
      if (!cntZero) begin
        waitCnt <= waitCnt - 1'b1;
      end else begin
        armed <= 1'b0;
      end
    end else begin
      armed <= 1'b0;
    end
  end

  assign readyInt = accessPh & armed & cntZero;

  always_comb begin
    strb.done = readyInt;
    strb.wrEn = readyInt & pwrite & ~addrBad;
    strb.rdEn = accessPh & ~pwrite;
    strb.err  = readyInt & addrBad;
  end

  assign pready  = readyInt;
  assign pslverr = strb.err;

endmodule

// File: rtl/apb_wait_regs_dp.sv
module apb_wait_regs_dp
  import apb_wait_regs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  ctrlStrb_t         strb,
  output logic              addrBad,
  output logic [DATA_W-1:0] prdata
);

  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int IDX_LSB = BYTE_W;
  localparam int HI_LSB  = BYTE_W + IDX_W;

  logic [IDX_W-1:0]                  regIdx;
  logic [NUM_REGS-1:0][DATA_W-1:0]   regFile;

  assign regIdx  = paddr[HI_LSB-1:IDX_LSB];
  assign addrBad = |paddr[ADDR_W-1:HI_LSB];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        wordQ <= '0;
      end else if (strb.wrEn && (regIdx == IDX_W'(g))) begin
        wordQ <= pwdata;
      end
    end
    assign regFile[g] = wordQ;
  end

  // Read data: selected word during a read access, zero when out of window
  always_comb begin
    if (strb.rdEn && !addrBad) begin
      prdata = regFile[regIdx];
    end else begin
      prdata = '0;
    end
  end

endmodule

// File: rtl/apb_wait_regs.sv
module apb_wait_regs
  import apb_wait_regs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int WAIT_W   = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [WAIT_W-1:0] waitCycles,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);

  ctrlStrb_t strb;
  logic      addrBad;

  apb_wait_regs_ctrl #(
    .WAIT_W (WAIT_W)
  ) u_ctrl (
    .pclk       (pclk),
    .presetn    (presetn),
    .waitCycles (waitCycles),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .addrBad    (addrBad),
    .strb       (strb),
    .pready     (pready),
    .pslverr    (pslverr)
  );

  apb_wait_regs_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .pclk    (pclk),
    .presetn (presetn),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .strb    (strb),
    .addrBad (addrBad),
    .prdata  (prdata)
  );

endmodule

// File: rtl/apb_wait_regs_checker.sv
module apb_wait_regs_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input logic              pclk,
  input logic              presetn,
  input logic [WAIT_W-1:0] waitCycles,
  input logic [ADDR_W-1:0] paddr,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr
);

  logic seenClk;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) seenClk <= 1'b0;
    else          seenClk <= 1'b1;
  end

  // R1: ready held low throughout reset
  always @(negedge pclk) begin
    if (presetn === 1'b0) begin
      p_reset_quiet_r1: assert (pready == 1'b0 && pslverr == 1'b0);
    end
  end

  // R3: ready only within an access phase
  p_ready_in_access_r3: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (psel && penable));

  // R7: error only on a completing cycle
  p_err_on_done_r7: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> pready);

  // R2: zero wait count completes on the first access cycle
  p_zero_wait_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (seenClk && psel && penable && $past(psel && !penable) && ($past(waitCycles) == '0))
      |-> pready);

  // R2: a nonzero wait count keeps the first access cycle not ready
  p_wait_delays_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (seenClk && psel && penable && $past(psel && !penable) && ($past(waitCycles) != '0))
      |-> !pready);

  // R6: an erroring read returns zero
  p_err_read_zero_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && !pwrite) |-> (prdata == '0));

  // R6: an error is raised exactly for out-of-window addresses
  p_err_matches_addr_r6: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (pslverr == (paddr[ADDR_W-1:4] != '0)));

endmodule

bind apb_wait_regs apb_wait_regs_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WAIT_W (WAIT_W)
) u_chk (
  .pclk       (pclk),
  .presetn    (presetn),
  .waitCycles (waitCycles),
  .paddr      (paddr),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .prdata     (prdata),
  .pready     (pready),
  .pslverr    (pslverr)
);

// File: tb/apb_wait_regs_bench.sv
module apb_wait_regs_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WAIT_W = 4;

  logic              pclk = 1'b0;
  logic              presetn;
  logic [WAIT_W-1:0] waitCycles;
  logic [ADDR_W-1:0] paddr;
  logic              psel;
  logic              penable;
  logic              pwrite;
  logic [DATA_W-1:0] pwdata;
  logic [DATA_W-1:0] prdata;
  logic              pready;
  logic              pslverr;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] model [4];
  logic [DATA_W-1:0] gotData;
  logic              gotErr;
  int                gotAccess;

  always #5 pclk = ~pclk;

  apb_wait_regs #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .NUM_REGS (4), .WAIT_W (WAIT_W)
  ) u_apb_wait_regs (
    .pclk (pclk), .presetn (presetn), .waitCycles (waitCycles),
    .paddr (paddr), .psel (psel), .penable (penable), .pwrite (pwrite),
    .pwdata (pwdata), .prdata (prdata), .pready (pready), .pslverr (pslverr)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves the bus idle at a later negedge.
  task automatic xfer(input logic [ADDR_W-1:0] a, input bit wr, input logic [DATA_W-1:0] wd);
    psel = 1'b1; penable = 1'b0; paddr = a; pwrite = wr; pwdata = wd;
    #1;
    chk(pready == 1'b0, "R3 ready in setup", {31'b0, pready}, 32'd0);
    @(negedge pclk);
    penable = 1'b1;
    gotAccess = 1;
    #1;
    while (!pready && gotAccess < 40) begin
      chk(pslverr == 1'b0, "R7 err during wait", {31'b0, pslverr}, 32'd0);
      @(negedge pclk);
      gotAccess++;
      #1;
    end
    gotData = prdata;
    gotErr  = pslverr;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idleCheck();
    #1;
    chk(pready == 1'b0 && pslverr == 1'b0, "R3 R7 idle outputs",
        {30'b0, pready, pslverr}, 32'd0);
    @(negedge pclk);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    presetn = 1'b0; waitCycles = '0; paddr = '0; psel = 1'b1; penable = 1'b1;
    pwrite = 1'b0; pwdata = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) begin
      @(negedge pclk);
      // R1: no ready or error while in reset
      chk(pready == 1'b0 && pslverr == 1'b0, "R1 quiet in reset",
          {30'b0, pready, pslverr}, 32'd0);
    end
    psel = 1'b0; penable = 1'b0;
    presetn = 1'b1;
    @(negedge pclk);
    idleCheck();

    // R1: registers cleared by reset
    for (int i = 0; i < 4; i++) begin
      xfer(ADDR_W'(i * 4), 1'b0, '0);
      chk(gotData == 32'd0, "R1 reset value", gotData, 32'd0);
    end

    for (int wi = 0; wi < 5; wi++) begin
      int w;
      w = (wi < 4) ? wi : 15;
      waitCycles = WAIT_W'(w);
      idleCheck();
      // R4 R5 R2 R8: writes at every offset, each followed directly by a read
      for (int idx = 0; idx < 4; idx++) begin
        for (int off = 0; off < 4; off++) begin
          logic [DATA_W-1:0] d;
          d = 32'hA000_0000 + (w << 16) + (idx << 8) + (off << 4) + idx;
          xfer(ADDR_W'(idx * 4 + off), 1'b1, d);
          model[idx] = d;
          chk(gotAccess == w + 1, "R2 R8 write length", gotAccess, w + 1);
          chk(gotErr == 1'b0, "R7 valid write err", {31'b0, gotErr}, 32'd0);
          xfer(ADDR_W'(idx * 4 + ((off + 1) % 4)), 1'b0, 32'hFFFF_FFFF);
          chk(gotData == model[idx], "R4 R5 readback", gotData, model[idx]);
          chk(gotAccess == w + 1, "R2 R8 read length", gotAccess, w + 1);
        end
      end
      idleCheck();
      // R6: out-of-window accesses with a single stray bit
      for (int b = 4; b < ADDR_W; b += 9) begin
        logic [ADDR_W-1:0] badA;
        badA = (ADDR_W'(1) << b) | ADDR_W'((b % 4) * 4);
        xfer(badA, 1'b1, 32'h5A5A_0000 + b);
        chk(gotErr == 1'b1, "R6 bad write err", {31'b0, gotErr}, 32'd1);
        chk(gotAccess == w + 1, "R2 bad write length", gotAccess, w + 1);
        xfer(badA, 1'b0, '0);
        chk(gotErr == 1'b1, "R6 bad read err", {31'b0, gotErr}, 32'd1);
        chk(gotData == 32'd0, "R6 bad read zero", gotData, 32'd0);
      end
      // R6: registers untouched by dropped writes
      for (int idx = 0; idx < 4; idx++) begin
        xfer(ADDR_W'(idx * 4), 1'b0, '0);
        chk(gotData == model[idx], "R6 regs unchanged", gotData, model[idx]);
        chk(gotErr == 1'b0, "R7 valid read err", {31'b0, gotErr}, 32'd0);
      end
      idleCheck();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule